// File: doc/BRIEF.md
# Selectable Reference Pulse Generator

This block derives a periodic reference signal from the main oscillator. The oscillator arrives as a single-cycle enable `osc_tick`, nominally at 76.8 kHz, inside a faster system clock. A two-bit rate selection picks one of four outputs:

- a fast train averaging 32768 Hz;
- a 50 Hz square wave;
- a 2 Hz pulse;
- one pulse per minute.

The fast train cannot have a fixed period. A fractional accumulator places exactly 32 pulses in every 75 oscillator cycles, and no two of those pulses are adjacent. All rates other than the square wave produce pulses that last one oscillator period.

A receiver-enable input suppresses the once-per-minute pulse while it is high. A suppressed pulse is dropped, not delayed. Any change of the selection restarts every divider, so the first pulse at the new rate arrives one full period after the change.

Top module: `ref_pulse_gen`

## Requirements
- R1: While reset is asserted and on release, `ref_out` is 0.
- R2: With `rate_sel` = 0 (fast rate), `ref_out` is high after exactly 32 of every 75 consecutive oscillator ticks. Counting ticks from the selection or reset, the first high follows tick 3.
- R3: In the fast rate, a tick that leaves `ref_out` high is always followed by a tick that leaves it low, so every pulse lasts one oscillator period.
- R4: With `rate_sel` = 1 (square wave), `ref_out` starts low and toggles after every `SQ_HALF_TICKS` ticks. After tick k it equals (k / `SQ_HALF_TICKS`) mod 2.
- R5: With `rate_sel` = 2 (slow pulse), `ref_out` is high for one tick period after every `SLOW_TICKS`-th tick and low otherwise.
- R6: With `rate_sel` = 3 (minute pulse), `ref_out` is high for one tick period after every (`SLOW_TICKS` × `MIN_MULT`)-th tick and low otherwise.
- R7: In the minute rate, a boundary tick that arrives while `rx_enable` is 1 produces no pulse.
- R8: A minute pulse suppressed by `rx_enable` is dropped, not delayed. No pulse appears between that boundary and the next one, and the next boundary with `rx_enable` at 0 pulses normally.
- R9: `rx_enable` has no effect on the fast, square and slow rates.
- R10: A change of `rate_sel` restarts all dividers. Timing at the new rate counts from the change, as if from reset.
- R11: On the clock edge after `rate_sel` changes, `ref_out` is 0.
- R12: On a clock edge with no oscillator tick and no selection change, `ref_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per main-oscillator period |
| rate_sel | input | 2 | Rate selection: 0 fast, 1 square, 2 slow, 3 minute |
| rx_enable | input | 1 | Receiver enabled; suppresses the minute pulse |
| ref_out | output | 1 | Reference output |

## Verification
A corrupted accumulator in the fractional path appears as a wrong pulse count within one 75-tick window. It can also appear as two adjacent high ticks, which is visible on the next oscillator tick. A divider that misses its clear on a selection change moves the first pulse earlier than one full period, which shows up in the first period after the change. A wrongly applied hold-off shows up either as a missing or late pulse at the next minute boundary, or as a stray pulse in the fast, square or slow rates.

// File: rtl/refgen_pkg.sv
package refgen_pkg;

   typedef enum logic [1:0] {
      RATE_FAST    = 2'd0,
      RATE_SQUARE  = 2'd1,
      RATE_SLOW    = 2'd2,
      RATE_MINUTE  = 2'd3
   } rate_e;

endpackage

// File: rtl/refgen_frac.sv
// Fractional pulse spreader: NUM pulses per DEN advances, evenly spaced.
module refgen_frac #(
   parameter int NUM = 32,
   parameter int DEN = 75
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic hit
);
   localparam int AW = $clog2(NUM + DEN + 1);

   logic [AW-1:0] acc_q;
   logic [AW-1:0] sum;
   logic          over;

   always_comb begin
      sum  = acc_q + AW'(NUM);
      over = (sum >= AW'(DEN));
      hit  = adv && over;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (adv) begin
         acc_q <= over ? (sum - AW'(DEN)) : sum;
      end
   end
endmodule

// File: rtl/refgen_div.sv
// Modulo-MOD advance counter with a wrap strobe on the final advance.
module refgen_div #(
   parameter int MOD = 768
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic wrap
);
   generate
      if (MOD == 1) begin : g_pass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ clr;
         assign wrap = adv;
      end else begin : g_count
         localparam int CW = $clog2(MOD);
         logic [CW-1:0] cnt_q;
         logic          at_end;

         assign at_end = (cnt_q == CW'(MOD - 1));
         assign wrap   = adv && at_end;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (clr) begin
               cnt_q <= '0;
            end else if (adv) begin
               cnt_q <= at_end ? '0 : cnt_q + CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/refgen_square.sv
// Toggle stage: level flips on every strobe, cleared low.
module refgen_square (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic flip,
   output logic level
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= 1'b0;
      end else if (clr) begin
         level <= 1'b0;
      end else if (flip) begin
         level <= ~level;
      end
   end
endmodule

// File: rtl/ref_pulse_gen.sv
module ref_pulse_gen
   import refgen_pkg::*;
#(
   parameter int FRAC_NUM      = 32,
   parameter int FRAC_DEN      = 75,
   parameter int SQ_HALF_TICKS = 768,
   parameter int SLOW_TICKS    = 38400,
   parameter int MIN_MULT      = 120
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic [1:0] rate_sel,
   input  logic       rx_enable,
   output logic       ref_out
);
   localparam int MIN_TICKS = SLOW_TICKS * MIN_MULT;

   generate
      if (FRAC_NUM < 1 || FRAC_NUM * 2 > FRAC_DEN) begin : g_bad_frac
         $error("FRAC_NUM must be in 1..FRAC_DEN/2");
      end
      if (SQ_HALF_TICKS < 2) begin : g_bad_sq
         $error("SQ_HALF_TICKS must be at least 2");
      end
      if (SLOW_TICKS < 2) begin : g_bad_slow
         $error("SLOW_TICKS must be at least 2");
      end
      if (MIN_MULT < 1 || MIN_TICKS < 2) begin : g_bad_min
         $error("MIN_MULT must be at least 1");
      end
   endgenerate

   logic [1:0] sel_q;
   logic       sel_chg;
   rate_e      rate;
   logic       frac_hit;
   logic       sq_wrap;
   logic       sq_lvl;
   logic       slow_wrap;
   logic       min_wrap;
   logic       nxt;
   logic       ref_q;

   assign sel_chg = (rate_sel != sel_q);
   assign rate    = rate_e'(rate_sel);

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= 2'd0;
      else        sel_q <= rate_sel;
   end

   refgen_frac #(.NUM(FRAC_NUM), .DEN(FRAC_DEN)) u_frac (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .adv(osc_tick), .hit(frac_hit)
   );

   refgen_div #(.MOD(SQ_HALF_TICKS)) u_sq_div (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .adv(osc_tick), .wrap(sq_wrap)
   );

   refgen_square u_sq (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .flip(sq_wrap), .level(sq_lvl)
   );

   refgen_div #(.MOD(SLOW_TICKS)) u_slow_div (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .adv(osc_tick), .wrap(slow_wrap)
   );

   refgen_div #(.MOD(MIN_MULT)) u_min_div (
      .clk(clk), .rst_n(rst_n), .clr(sel_chg), .adv(slow_wrap), .wrap(min_wrap)
   );

   always_comb begin
      unique case (rate)
         RATE_FAST:   nxt = frac_hit;
         RATE_SQUARE: nxt = sq_lvl ^ sq_wrap;
         RATE_SLOW:   nxt = slow_wrap;
         RATE_MINUTE: nxt = min_wrap && !rx_enable;
         default:     nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q <= 1'b0;
      end else if (sel_chg) begin
         ref_q <= 1'b0;
      end else if (osc_tick) begin
         ref_q <= nxt;
      end
   end

   assign ref_out = ref_q;
endmodule

// File: rtl/refgen_chk.sv
module refgen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       osc_tick,
   input logic [1:0] rate_sel,
   input logic       rx_enable,
   input logic       ref_out
);
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_tick && rate_sel == $past(rate_sel)) |=> $stable(ref_out)); // R12

   AST_FAST_NO_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && rate_sel == 2'd0 && ref_out) |=> !ref_out); // R3

   AST_SLOW_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && rate_sel == 2'd2 && ref_out) |=> !ref_out); // R5

   AST_MIN_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (osc_tick && rate_sel == 2'd3 && rx_enable) |=> !ref_out); // R7

   AST_SEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rate_sel != $past(rate_sel)) |=> !ref_out); // R11
endmodule

bind ref_pulse_gen refgen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
   .rate_sel(rate_sel), .rx_enable(rx_enable), .ref_out(ref_out)
);

// File: tb/tb_ref_pulse_gen.sv
module tb_ref_pulse_gen;
   localparam int HALF = 4;
   localparam int SLOW = 6;
   localparam int MM   = 3;
   localparam int MINT = SLOW * MM;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       osc_tick = 1'b0;
   logic [1:0] rate_sel = 2'd0;
   logic       rx_enable = 1'b0;
   logic       ref_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ref_pulse_gen #(.SQ_HALF_TICKS(HALF), .SLOW_TICKS(SLOW), .MIN_MULT(MM)) dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .rate_sel(rate_sel),
      .rx_enable(rx_enable), .ref_out(ref_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick_once();
      @(negedge clk) osc_tick = 1'b1;
      @(negedge clk) osc_tick = 1'b0;
   endtask

   task automatic set_rate(input logic [1:0] r);
      @(negedge clk) rate_sel = r;
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 in reset", ref_out, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", ref_out, 0);
   endtask

   task automatic t_fast();
      int first = 0, w0 = 0, w1 = 0, adj = 0;
      bit prev = 1'b0;
      rx_enable = 1'b1;  // R9: no effect on fast rate
      for (int k = 1; k <= 150; k++) begin
         tick_once();
         if (ref_out && first == 0) first = k;
         if (ref_out && k <= 75) w0++;
         if (ref_out && k > 75) w1++;
         if (ref_out && prev) adj++;
         prev = ref_out;
      end
      rx_enable = 1'b0;
      chk("R2 first pulse tick", first, 3);
      chk("R2 window 1 count", w0, 32);
      chk("R2 window 2 count (R9 rx high)", w1, 32);
      chk("R3 adjacent highs", adj, 0);
   endtask

   task automatic t_square();
      int bad = 0;
      set_rate(2'd1);
      for (int k = 1; k <= 24; k++) begin
         tick_once();
         if (k == 13) rx_enable = 1'b1;
         if (ref_out != ((k / HALF) % 2)) bad++;
      end
      rx_enable = 1'b0;
      chk("R4 square mismatches (R9)", bad, 0);
   endtask

   task automatic t_slow();
      int bad = 0;
      set_rate(2'd2);
      rx_enable = 1'b1;
      for (int k = 1; k <= 5 * SLOW; k++) begin
         tick_once();
         if (ref_out != (k % SLOW == 0)) bad++;
      end
      rx_enable = 1'b0;
      chk("R5 slow mismatches (R9 rx high)", bad, 0);
   endtask

   task automatic t_minute();
      int bad = 0;
      set_rate(2'd3);
      for (int k = 1; k <= 3 * MINT; k++) begin
         tick_once();
         if (ref_out != (k % MINT == 0)) bad++;
      end
      chk("R6 minute mismatches", bad, 0);
   endtask

   task automatic t_holdoff();
      int hi_a = 0, hi_b = 0, at_end = 0;
      set_rate(2'd2);
      set_rate(2'd3);
      rx_enable = 1'b1;
      for (int k = 1; k <= MINT; k++) begin
         tick_once();
         if (ref_out) hi_a++;
      end
      rx_enable = 1'b0;
      for (int k = MINT + 1; k <= 2 * MINT; k++) begin
         tick_once();
         if (ref_out && k < 2 * MINT) hi_b++;
         if (k == 2 * MINT) at_end = ref_out;
      end
      chk("R7 pulses during hold-off", hi_a, 0);
      chk("R8 late pulse after drop", hi_b, 0);
      chk("R8 next boundary pulse", at_end, 1);
   endtask

   task automatic t_restart();
      int first = 0;
      set_rate(2'd2);
      repeat (4) tick_once();
      set_rate(2'd3);
      set_rate(2'd2);
      for (int k = 1; k <= SLOW; k++) begin
         tick_once();
         if (ref_out && first == 0) first = k;
      end
      chk("R10 first slow pulse after change", first, SLOW);
   endtask

   task automatic t_clear_and_hold();
      set_rate(2'd1);
      repeat (HALF) tick_once();
      chk("R4 square high after half period", ref_out, 1);
      repeat (20) @(negedge clk);
      chk("R12 holds without ticks", ref_out, 1);
      @(negedge clk) rate_sel = 2'd0;
      @(negedge clk);
      chk("R11 low after selection change", ref_out, 0);
   endtask

   initial begin
      t_reset();
      t_fast();
      t_square();
      t_slow();
      t_minute();
      t_holdoff();
      t_restart();
      t_clear_and_hold();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule